// File: doc/BRIEF.md
# Dual-Timer Peripheral Register Block

This block is a byte-wide register file for a general-purpose interface adapter. A host reaches sixteen byte registers through a single-cycle bus made of a chip select, a write strobe, a four-bit register index and separate write and read data buses. Behind the registers are two eight-bit output ports, each with its own direction mask, and two sixteen-bit down-counters with reload latches. The block also holds a shift data byte, an auxiliary control byte, a peripheral control byte, and a pair of interrupt flag and enable registers that drive one level-sensitive interrupt line.

The counters advance only on cycles where the `tick_en` strobe is high. Timer 1 either fires once per load or runs free. In free-running mode it reloads from its latch every `latch+2` ticks. Timer 2 always fires once per load. The shift data byte is plain storage. An outside agent pulses `sr_done` to report that a shift has finished. Interrupt flags are cleared by writing ones to the flag register or as a side effect of reading certain registers. A flag event that lands in the same cycle as a clear always wins.

Top module: `dual_timer_pif`

## Requirements
- R1: After reset, the port B direction mask reads 0xFF. The ports, port A direction, shift byte, auxiliary and peripheral bytes and the flags read 0, and the enable register reads 0x80. Both timer latches and both counters read 0xFFFF, and the interrupt line is low.
- R2: A write to port B (index 0) or to port A (index 1, or its alias at index 15) changes only the bits whose direction bit is 1. The other bits keep their value. Port B direction is at index 2 and port A direction is at index 3.
- R3: A write to the enable register (index 14) with bit 7 set ORs bits 6:0 into the enables. With bit 7 clear, it clears the enables named in bits 6:0. A read returns the enables with bit 7 forced to 1.
- R4: A read of the flag register (index 13) returns the flags in bits 6:0 and sets bit 7 when any flag is pending and enabled. Writing ones to it clears those flags. `irq` is high while a flag among shift (0x04), timer 2 (0x20) and timer 1 (0x40) is both set and enabled.
- R5: A write to index 5 loads timer 1 from its latch. With auxiliary bits 7:6 not equal to 01, the timer 1 flag rises on tick `latch+2` and rises only once per load. The counter passes through 0xFFFF and keeps decrementing.
- R6: With auxiliary bits 7:6 equal to 01, timer 1 reloads from its latch at the end of each `latch+2`-tick period and raises its flag each period.
- R7: Writes to index 4 or 6 set only the timer 1 latch low byte. A write to index 7 sets the latch high byte and clears the timer 1 flag but leaves the counter alone. A write to index 5 sets the high byte, clears the flag and loads the counter from the full latch.
- R8: A read of index 4 clears the timer 1 flag, a read of index 8 clears the timer 2 flag, and a read of index 10 clears the shift flag. Reads of index 5 or 9 clear nothing.
- R9: A write to index 8 sets the timer 2 latch low byte. A write to index 9 sets the high byte, clears the timer 2 flag and loads the counter. The flag rises when the counter steps from 0 to 0xFFFF, which is tick `latch+1`, and never again until the next load.
- R10: The counters hold their value on every cycle without `tick_en`.
- R11: The shift byte at index 10 is read/write storage. A one-cycle `sr_done` pulse sets the shift flag.
- R12: When a flag is raised in the same cycle as a read or write that clears that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance strobe |
| cs | input | 1 | Register access select |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register index |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid in the access cycle, 0 otherwise |
| sr_done | input | 1 | Shift-complete pulse from outside |
| pa_out | output | DW | Port A register |
| pa_dir | output | DW | Port A direction mask (1 = output) |
| pb_out | output | DW | Port B register |
| pb_dir | output | DW | Port B direction mask (1 = output) |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can fall in the same cycle. The first is a counter underflow that raises a flag together with a bus access that clears the same flag. The second is the external shift-complete pulse together with a flag-register write that clears the shift flag. The bench loads timer 2 with zero and drives `tick_en` in the same cycle as a read of the timer 2 low counter byte. It also raises `sr_done` in the same cycle as a write of 0x04 to the flag register. In both cases it then reads the flag register, and the flag must still be set.

// File: rtl/dtpif_pkg.sv
package dtpif_pkg;

   typedef enum logic [3:0] {
      RI_PB        = 4'd0,
      RI_PA        = 4'd1,
      RI_PB_DIR    = 4'd2,
      RI_PA_DIR    = 4'd3,
      RI_T1_CNT_LO = 4'd4,
      RI_T1_CNT_HI = 4'd5,
      RI_T1_LAT_LO = 4'd6,
      RI_T1_LAT_HI = 4'd7,
      RI_T2_CNT_LO = 4'd8,
      RI_T2_CNT_HI = 4'd9,
      RI_SHIFT     = 4'd10,
      RI_AUX       = 4'd11,
      RI_PERIPH    = 4'd12,
      RI_FLAGS     = 4'd13,
      RI_ENABLES   = 4'd14,
      RI_PA_ALIAS  = 4'd15
   } reg_idx_e;

   localparam int IDX_W   = 4;
   localparam int N_REGS  = 1 << IDX_W;
   localparam int FLAG_W  = 7;
   localparam int FB_SR   = 2;
   localparam int FB_T2   = 5;
   localparam int FB_T1   = 6;
   localparam logic [FLAG_W-1:0] IRQ_SRC_MASK = 7'h64;
   localparam logic [FLAG_W-1:0] SR_RD_CLEAR  = 7'h1C;
   localparam logic [1:0] T1_MODE_FREE = 2'b01;

endpackage

// File: rtl/dtpif_port.sv
module dtpif_port #(
   parameter int DW = 8,
   parameter logic [DW-1:0] DIR_RST = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dir_we,
   input  logic          dat_we,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] dat,
   output logic [DW-1:0] dir
);

   logic [DW-1:0] dat_q;
   logic [DW-1:0] dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dat_q <= '0;
         dir_q <= DIR_RST;
      end else begin
         if (dir_we) dir_q <= wdata;
         if (dat_we) dat_q <= (dat_q & ~dir_q) | (wdata & dir_q);
      end
   end

   assign dat = dat_q;
   assign dir = dir_q;

endmodule

// File: rtl/dtpif_timer.sv
module dtpif_timer #(
   parameter int TW      = 16,
   parameter bit FREE_OK = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            lo_we,
   input  logic            hi_we,
   input  logic            load,
   input  logic            free,
   input  logic [TW/2-1:0] wbyte,
   output logic [TW-1:0]   cnt,
   output logic [TW-1:0]   lat,
   output logic            expire
);

   localparam int HW = TW / 2;
   localparam logic [TW-1:0] ALL1 = '1;

   if ((TW % 2) != 0) begin : g_bad_tw
      $error("dtpif_timer: TW must be even");
   end

   logic [TW-1:0] cnt_q, cnt_d, lat_q, lat_d;
   logic          wrap_q, wrap_d, armed_q, armed_d, exp_c;

   always_comb begin
      lat_d = lat_q;
      if (lo_we) lat_d[HW-1:0]  = wbyte;
      if (hi_we) lat_d[TW-1:HW] = wbyte;
   end

   if (FREE_OK) begin : g_t1
      // Period of latch+2: down to 0, one tick at all-ones, then the end tick.
      always_comb begin
         cnt_d   = cnt_q;
         wrap_d  = wrap_q;
         armed_d = armed_q;
         exp_c   = 1'b0;
         if (load) begin
            cnt_d   = lat_d;
            wrap_d  = 1'b0;
            armed_d = 1'b1;
         end else if (tick) begin
            if (wrap_q) begin
               exp_c   = free | armed_q;
               armed_d = 1'b0;
               wrap_d  = 1'b0;
               cnt_d   = free ? lat_d : cnt_q - TW'(1);
            end else if (cnt_q == '0) begin
               cnt_d  = ALL1;
               wrap_d = 1'b1;
            end else begin
               cnt_d = cnt_q - TW'(1);
            end
         end
      end
   end else begin : g_t2
      logic unused_in;
      assign unused_in = free ^ wrap_q;
      always_comb begin
         cnt_d   = cnt_q;
         wrap_d  = 1'b0;
         armed_d = armed_q;
         exp_c   = 1'b0;
         if (load) begin
            cnt_d   = lat_d;
            armed_d = 1'b1;
         end else if (tick) begin
            cnt_d = cnt_q - TW'(1);
            if (cnt_q == '0 && armed_q) begin
               exp_c   = 1'b1;
               armed_d = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= ALL1;
         lat_q   <= ALL1;
         wrap_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         cnt_q   <= cnt_d;
         lat_q   <= lat_d;
         wrap_q  <= wrap_d;
         armed_q <= armed_d;
      end
   end

   assign cnt    = cnt_q;
   assign lat    = lat_q;
   assign expire = exp_c;

endmodule

// File: rtl/dtpif_irq.sv
module dtpif_irq #(
   parameter int FW = 7,
   parameter logic [FW-1:0] SRC_MASK = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [FW-1:0] set_v,
   input  logic [FW-1:0] clr_v,
   input  logic          en_we,
   input  logic [FW:0]   en_wdata,
   output logic [FW-1:0] ifr,
   output logic [FW-1:0] ier,
   output logic          any_pend,
   output logic          irq
);

   logic [FW-1:0] ifr_q, ier_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ifr_q <= '0;
         ier_q <= '0;
      end else begin
         ifr_q <= (ifr_q & ~clr_v) | set_v;
         if (en_we) begin
            if (en_wdata[FW]) ier_q <= ier_q | en_wdata[FW-1:0];
            else              ier_q <= ier_q & ~en_wdata[FW-1:0];
         end
      end
   end

   assign ifr      = ifr_q;
   assign ier      = ier_q;
   assign any_pend = |(ifr_q & ier_q);
   assign irq      = |(ifr_q & ier_q & SRC_MASK);

endmodule

// File: rtl/dual_timer_pif.sv
module dual_timer_pif
   import dtpif_pkg::*;
#(
   parameter int DW = 8,
   parameter int TW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cs,
   input  logic             wr,
   input  logic [IDX_W-1:0] addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   input  logic             sr_done,
   output logic [DW-1:0]    pa_out,
   output logic [DW-1:0]    pa_dir,
   output logic [DW-1:0]    pb_out,
   output logic [DW-1:0]    pb_dir,
   output logic             irq
);

   localparam int FW = DW - 1;

   if (DW != FLAG_W + 1) begin : g_bad_dw
      $error("dual_timer_pif: DW must be FLAG_W+1");
   end
   if (TW != 2 * DW) begin : g_bad_tw
      $error("dual_timer_pif: TW must be twice DW");
   end

   // ---------------- decode ----------------
   logic [N_REGS-1:0] wr_hit;
   for (genvar gi = 0; gi < N_REGS; gi++) begin : g_dec
      assign wr_hit[gi] = cs && wr && (addr == IDX_W'(gi));
   end

   logic rd_cyc, rd_t1lo, rd_t2lo, rd_sr;
   assign rd_cyc  = cs && !wr;
   assign rd_t1lo = rd_cyc && (addr == RI_T1_CNT_LO);
   assign rd_t2lo = rd_cyc && (addr == RI_T2_CNT_LO);
   assign rd_sr   = rd_cyc && (addr == RI_SHIFT);

   // ---------------- ports ----------------
   dtpif_port #(.DW(DW), .DIR_RST('1)) u_pb (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_we (wr_hit[RI_PB_DIR]),
      .dat_we (wr_hit[RI_PB]),
      .wdata  (wdata),
      .dat    (pb_out),
      .dir    (pb_dir)
   );

   dtpif_port #(.DW(DW), .DIR_RST('0)) u_pa (
      .clk    (clk),
      .rst_n  (rst_n),
      .dir_we (wr_hit[RI_PA_DIR]),
      .dat_we (wr_hit[RI_PA] | wr_hit[RI_PA_ALIAS]),
      .wdata  (wdata),
      .dat    (pa_out),
      .dir    (pa_dir)
   );

   // ---------------- plain storage ----------------
   logic [DW-1:0] sr_q, acr, pcr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sr_q <= '0;
         acr  <= '0;
         pcr  <= '0;
      end else begin
         if (wr_hit[RI_SHIFT])  sr_q <= wdata;
         if (wr_hit[RI_AUX])    acr  <= wdata;
         if (wr_hit[RI_PERIPH]) pcr  <= wdata;
      end
   end

   // ---------------- timers ----------------
   logic [TW-1:0] t1_cnt, t1_lat, t2_cnt, t2_lat_unused;
   logic          t1_exp, t2_exp, t1_free;

   assign t1_free = (acr[DW-1:DW-2] == T1_MODE_FREE);

   dtpif_timer #(.TW(TW), .FREE_OK(1'b1)) u_t1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_en),
      .lo_we  (wr_hit[RI_T1_CNT_LO] | wr_hit[RI_T1_LAT_LO]),
      .hi_we  (wr_hit[RI_T1_CNT_HI] | wr_hit[RI_T1_LAT_HI]),
      .load   (wr_hit[RI_T1_CNT_HI]),
      .free   (t1_free),
      .wbyte  (wdata),
      .cnt    (t1_cnt),
      .lat    (t1_lat),
      .expire (t1_exp)
   );

   dtpif_timer #(.TW(TW), .FREE_OK(1'b0)) u_t2 (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_en),
      .lo_we  (wr_hit[RI_T2_CNT_LO]),
      .hi_we  (wr_hit[RI_T2_CNT_HI]),
      .load   (wr_hit[RI_T2_CNT_HI]),
      .free   (1'b0),
      .wbyte  (wdata),
      .cnt    (t2_cnt),
      .lat    (t2_lat_unused),
      .expire (t2_exp)
   );

   // ---------------- flags ----------------
   logic [FW-1:0] set_v, clr_v, ifr, ier;
   logic          any_pend;

   always_comb begin
      set_v        = '0;
      set_v[FB_T1] = t1_exp;
      set_v[FB_T2] = t2_exp;
      set_v[FB_SR] = sr_done;
   end

   always_comb begin
      clr_v = '0;
      if (wr_hit[RI_FLAGS]) clr_v = wdata[FW-1:0];
      if (rd_t1lo || wr_hit[RI_T1_CNT_HI] || wr_hit[RI_T1_LAT_HI]) clr_v[FB_T1] = 1'b1;
      if (rd_t2lo || wr_hit[RI_T2_CNT_HI]) clr_v[FB_T2] = 1'b1;
      if (rd_sr) clr_v = clr_v | SR_RD_CLEAR;
   end

   dtpif_irq #(.FW(FW), .SRC_MASK(IRQ_SRC_MASK)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_v    (set_v),
      .clr_v    (clr_v),
      .en_we    (wr_hit[RI_ENABLES]),
      .en_wdata (wdata),
      .ifr      (ifr),
      .ier      (ier),
      .any_pend (any_pend),
      .irq      (irq)
   );

   // ---------------- read mux ----------------
   always_comb begin
      rdata = '0;
      if (rd_cyc) begin
         case (reg_idx_e'(addr))
            RI_PB:        rdata = pb_out;
            RI_PA:        rdata = pa_out;
            RI_PB_DIR:    rdata = pb_dir;
            RI_PA_DIR:    rdata = pa_dir;
            RI_T1_CNT_LO: rdata = t1_cnt[DW-1:0];
            RI_T1_CNT_HI: rdata = t1_cnt[TW-1:DW];
            RI_T1_LAT_LO: rdata = t1_lat[DW-1:0];
            RI_T1_LAT_HI: rdata = t1_lat[TW-1:DW];
            RI_T2_CNT_LO: rdata = t2_cnt[DW-1:0];
            RI_T2_CNT_HI: rdata = t2_cnt[TW-1:DW];
            RI_SHIFT:     rdata = sr_q;
            RI_AUX:       rdata = acr;
            RI_PERIPH:    rdata = pcr;
            RI_FLAGS:     rdata = {any_pend, ifr};
            RI_ENABLES:   rdata = {1'b1, ier};
            RI_PA_ALIAS:  rdata = pa_out;
            default:      rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/dtpif_chk.sv
module dtpif_chk #(
   parameter int DW = 8,
   parameter int TW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_en,
   input logic          cs,
   input logic          wr,
   input logic [3:0]    addr,
   input logic [DW-1:0] wdata,
   input logic          sr_done,
   input logic [DW-1:0] pb_out,
   input logic [DW-1:0] pb_dir,
   input logic [TW-1:0] t1_cnt,
   input logic [TW-1:0] t1_lat,
   input logic          t1_exp,
   input logic [DW-2:0] ifr,
   input logic [DW-2:0] ier,
   input logic [DW-1:0] acr
);

   AST_PORT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == 4'd0) |=> pb_out == (($past(pb_out) & ~$past(pb_dir)) | ($past(wdata) & $past(pb_dir)))); // R2

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == 4'd14 && wdata[DW-1]) |=> ((ier & $past(wdata[DW-2:0])) == $past(wdata[DW-2:0]))); // R3

   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == 4'd14 && !wdata[DW-1]) |=> ((ier & $past(wdata[DW-2:0])) == '0)); // R3

   AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && wr && addr == 4'd5) |=> (t1_cnt == {$past(wdata), $past(t1_lat[DW-1:0])}) && !ifr[6]); // R7

   AST_T1_FREE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (t1_exp && acr[DW-1:DW-2] == 2'b01 && !(cs && wr)) |=> t1_cnt == $past(t1_lat)); // R6

   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !(cs && wr && addr == 4'd5)) |=> $stable(t1_cnt)); // R10

   AST_T1_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      t1_exp |=> ifr[6]); // R12

   AST_SR_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      sr_done |=> ifr[2]); // R11

endmodule

bind dual_timer_pif dtpif_chk #(.DW(DW), .TW(TW)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_en (tick_en),
   .cs      (cs),
   .wr      (wr),
   .addr    (addr),
   .wdata   (wdata),
   .sr_done (sr_done),
   .pb_out  (pb_out),
   .pb_dir  (pb_dir),
   .t1_cnt  (t1_cnt),
   .t1_lat  (t1_lat),
   .t1_exp  (t1_exp),
   .ifr     (ifr),
   .ier     (ier),
   .acr     (acr)
);

// File: tb/dual_timer_pif_tb_top.sv
module dual_timer_pif_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       cs = 1'b0;
   logic       wr = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       sr_done = 1'b0;
   logic [7:0] pa_out, pa_dir, pb_out, pb_dir;
   logic       irq;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dual_timer_pif dut_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .cs      (cs),
      .wr      (wr),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .sr_done (sr_done),
      .pa_out  (pa_out),
      .pa_dir  (pa_dir),
      .pb_out  (pb_out),
      .pb_dir  (pb_dir),
      .irq     (irq)
   );

   task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      cs = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] mask, input logic [7:0] exp);
      logic [7:0] d;
      bus_rd(a, d);
      check(req, $sformatf("reg %0d", a), {8'h00, d & mask}, {8'h00, exp});
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic t_reset;
      rd_chk("R1", 4'd2, 8'hFF, 8'hFF);
      rd_chk("R1", 4'd0, 8'hFF, 8'h00);
      rd_chk("R1", 4'd3, 8'hFF, 8'h00);
      rd_chk("R1", 4'd6, 8'hFF, 8'hFF);
      rd_chk("R1", 4'd7, 8'hFF, 8'hFF);
      rd_chk("R1", 4'd5, 8'hFF, 8'hFF);
      rd_chk("R1", 4'd4, 8'hFF, 8'hFF);
      rd_chk("R1", 4'd9, 8'hFF, 8'hFF);
      rd_chk("R1", 4'd10, 8'hFF, 8'h00);
      rd_chk("R1", 4'd11, 8'hFF, 8'h00);
      rd_chk("R1", 4'd12, 8'hFF, 8'h00);
      rd_chk("R1", 4'd13, 8'hFF, 8'h00);
      rd_chk("R1", 4'd14, 8'hFF, 8'h80);
      check("R1", "irq", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_ports;
      bus_wr(4'd3, 8'h0F);
      bus_wr(4'd1, 8'hFF);
      rd_chk("R2", 4'd1, 8'hFF, 8'h0F);
      check("R2", "pa_out", {8'h00, pa_out}, 16'h000F);
      bus_wr(4'd3, 8'hF0);
      bus_wr(4'd15, 8'hA5);
      rd_chk("R2", 4'd15, 8'hFF, 8'hAF);
      rd_chk("R2", 4'd1, 8'hFF, 8'hAF);
      bus_wr(4'd2, 8'h00);
      bus_wr(4'd0, 8'hFF);
      check("R2", "pb_out masked", {8'h00, pb_out}, 16'h0000);
      bus_wr(4'd2, 8'h81);
      bus_wr(4'd0, 8'hFF);
      rd_chk("R2", 4'd0, 8'hFF, 8'h81);
   endtask

   task automatic t_enables;
      bus_wr(4'd14, 8'hE0);
      rd_chk("R3", 4'd14, 8'hFF, 8'hE0);
      bus_wr(4'd14, 8'h20);
      rd_chk("R3", 4'd14, 8'hFF, 8'hC0);
      bus_wr(4'd14, 8'h84);
      rd_chk("R3", 4'd14, 8'hFF, 8'hC4);
      bus_wr(4'd14, 8'h7F);
      rd_chk("R3", 4'd14, 8'hFF, 8'h80);
   endtask

   task automatic t_t1_oneshot;
      bus_wr(4'd14, 8'hC0);
      bus_wr(4'd6, 8'h05);
      bus_wr(4'd5, 8'h00);
      rd_chk("R5", 4'd4, 8'hFF, 8'h05);
      ticks(6);
      rd_chk("R5", 4'd13, 8'hFF, 8'h00);
      check("R5", "irq before end", {15'd0, irq}, 16'd0);
      ticks(1);
      check("R4", "irq raised", {15'd0, irq}, 16'd1);
      rd_chk("R4", 4'd13, 8'hFF, 8'hC0);
      bus_wr(4'd13, 8'h40);
      rd_chk("R4", 4'd13, 8'hFF, 8'h00);
      check("R4", "irq after clear", {15'd0, irq}, 16'd0);
      rd_chk("R5", 4'd5, 8'hFF, 8'hFF);
      rd_chk("R5", 4'd4, 8'hFF, 8'hFE);
      ticks(20);
      rd_chk("R5", 4'd13, 8'h40, 8'h00);
   endtask

   task automatic t_t1_free;
      bus_wr(4'd11, 8'h40);
      bus_wr(4'd6, 8'h03);
      bus_wr(4'd5, 8'h00);
      ticks(4);
      rd_chk("R6", 4'd13, 8'h40, 8'h00);
      ticks(1);
      rd_chk("R6", 4'd13, 8'hFF, 8'hC0);
      rd_chk("R6", 4'd4, 8'hFF, 8'h03);
      rd_chk("R8", 4'd13, 8'h40, 8'h00);
      ticks(5);
      rd_chk("R6", 4'd13, 8'hFF, 8'hC0);
      bus_wr(4'd11, 8'h00);
   endtask

   task automatic t_t1_latch;
      bus_wr(4'd6, 8'h02);
      bus_wr(4'd5, 8'h00);
      ticks(4);
      rd_chk("R7", 4'd13, 8'h40, 8'h40);
      rd_chk("R8", 4'd5, 8'hFF, 8'hFF);
      rd_chk("R8", 4'd13, 8'h40, 8'h40);
      bus_wr(4'd6, 8'h12);
      bus_wr(4'd7, 8'h56);
      rd_chk("R7", 4'd13, 8'h40, 8'h00);
      rd_chk("R7", 4'd5, 8'hFF, 8'hFF);
      rd_chk("R7", 4'd6, 8'hFF, 8'h12);
      rd_chk("R7", 4'd7, 8'hFF, 8'h56);
      bus_wr(4'd4, 8'h9A);
      rd_chk("R7", 4'd6, 8'hFF, 8'h9A);
      rd_chk("R7", 4'd5, 8'hFF, 8'hFF);
      bus_wr(4'd5, 8'h01);
      rd_chk("R7", 4'd5, 8'hFF, 8'h01);
      rd_chk("R7", 4'd4, 8'hFF, 8'h9A);
   endtask

   task automatic t_t2;
      bus_wr(4'd14, 8'h40);
      bus_wr(4'd14, 8'hA0);
      bus_wr(4'd8, 8'h03);
      bus_wr(4'd9, 8'h00);
      rd_chk("R9", 4'd8, 8'hFF, 8'h03);
      ticks(3);
      rd_chk("R9", 4'd13, 8'h20, 8'h00);
      ticks(1);
      check("R9", "irq t2", {15'd0, irq}, 16'd1);
      rd_chk("R9", 4'd9, 8'hFF, 8'hFF);
      rd_chk("R9", 4'd13, 8'h20, 8'h20);
      rd_chk("R8", 4'd8, 8'hFF, 8'hFF);
      rd_chk("R8", 4'd13, 8'h20, 8'h00);
      ticks(65535);
      rd_chk("R9", 4'd8, 8'hFF, 8'h00);
      ticks(1);
      rd_chk("R9", 4'd13, 8'h20, 8'h00);
      check("R9", "irq no repeat", {15'd0, irq}, 16'd0);
      bus_wr(4'd9, 8'h00);
      ticks(4);
      rd_chk("R9", 4'd13, 8'h20, 8'h20);
   endtask

   task automatic t_tick_gate;
      bus_wr(4'd8, 8'h05);
      bus_wr(4'd9, 8'h00);
      repeat (10) @(negedge clk);
      rd_chk("R10", 4'd8, 8'hFF, 8'h05);
      rd_chk("R10", 4'd9, 8'hFF, 8'h00);
   endtask

   task automatic t_shift;
      bus_wr(4'd10, 8'h5A);
      rd_chk("R11", 4'd10, 8'hFF, 8'h5A);
      bus_wr(4'd14, 8'h84);
      @(negedge clk);
      sr_done = 1'b1;
      @(negedge clk);
      sr_done = 1'b0;
      rd_chk("R11", 4'd13, 8'h04, 8'h04);
      check("R11", "irq sr", {15'd0, irq}, 16'd1);
      rd_chk("R8", 4'd10, 8'hFF, 8'h5A);
      rd_chk("R8", 4'd13, 8'h04, 8'h00);
      check("R11", "irq after sr read", {15'd0, irq}, 16'd0);
   endtask

   task automatic t_same_cycle;
      bus_wr(4'd8, 8'h00);
      bus_wr(4'd9, 8'h00);
      @(negedge clk);
      tick_en = 1'b1; cs = 1'b1; wr = 1'b0; addr = 4'd8;
      @(negedge clk);
      tick_en = 1'b0; cs = 1'b0;
      rd_chk("R12", 4'd13, 8'h20, 8'h20);
      bus_wr(4'd13, 8'h7F);
      rd_chk("R12", 4'd13, 8'h7F, 8'h00);
      @(negedge clk);
      sr_done = 1'b1; cs = 1'b1; wr = 1'b1; addr = 4'd13; wdata = 8'h04;
      @(negedge clk);
      sr_done = 1'b0; cs = 1'b0; wr = 1'b0;
      rd_chk("R12", 4'd13, 8'h04, 8'h04);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ports();
      t_enables();
      t_t1_oneshot();
      t_t1_free();
      t_t1_latch();
      t_t2();
      t_tick_gate();
      t_shift();
      t_same_cycle();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule